// File: doc/BRIEF.md
# Five-Stage In-Order Integer Pipeline

This block is a scalar, in-order integer core split into five stages: fetch, decode with register read, execute, memory access and writeback. A pipeline register sits between each pair of neighbouring stages. It runs a small subset of a classic 32-bit load/store instruction set: four register-to-register ALU operations (add, subtract, AND, OR), word load, word store, and a branch taken when two registers are equal. Instruction and data storage are small internal word arrays. Each array is read combinationally and written at a clock edge.

The core has no interlocks, forwarding or squashing. Programs must place enough independent instructions or no-ops between dependent ones. Instructions fetched after a taken branch still run, so three slots must follow every branch. A load port fills either array while the core is held in reset. Debug read ports and a writeback monitor show the architectural state and the timing of every retirement.

Top module: `pipe5_core`

## Requirements
- R1: After reset is released, the instruction at word address k (byte address 4k) is fetched at clock edge k+1 and shows on the writeback monitor after edge k+4, when no taken branch comes earlier. Each instruction takes one cycle per stage.
- R2: An R-type word (opcode bits [31:26] = 0, rs [25:21], rt [20:16], rd [15:11], bits [10:6] = 0) with function code bits [5:0] = 0x20, 0x22, 0x24 or 0x25 writes rs+rt, rs−rt, rs AND rt or rs OR rt to rd. Any other function code or shift field acts as a no-op.
- R3: A load (opcode 0x23) writes to rt the data word at byte address rs plus the sign-extended 16-bit offset in bits [15:0]. Negative offsets are supported.
- R4: A store (opcode 0x2B) writes rt to the data word at rs plus the sign-extended offset during its memory stage. It writes no register.
- R5: A branch (opcode 0x04) is taken when rs equals rt. Its target is PC+4 plus the offset shifted left by 2. The PC takes the target at the edge that ends the branch's memory stage, so exactly three following instructions still execute. Otherwise the PC advances by 4.
- R6: Register 0 always reads as zero. A write to it changes nothing and raises no writeback event.
- R7: A register written in writeback is read with its new value by an instruction decoding in that same cycle.
- R8: While rst_n is low, the PC is 0, all pipeline registers hold bubbles, no writeback event shows, and every register reads zero.
- R9: The writeback monitor is raised only for ALU operations and loads with a nonzero destination. Stores and branches, taken or not, raise none.
- R10: A load-port write places a word at the chosen index of instruction memory (prog_dmem = 0) or data memory (prog_dmem = 1). The debug ports return register and data-memory contents combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; release synchronously |
| prog_we | input | 1 | Load-port write strobe |
| prog_dmem | input | 1 | Load-port target: 0 instruction memory, 1 data memory |
| prog_addr | input | PAW | Load-port word index |
| prog_data | input | 32 | Load-port write data |
| dbg_reg_sel | input | 5 | Debug register index |
| dbg_reg_val | output | 32 | Contents of the selected register |
| dbg_mem_sel | input | DMEM_AW | Debug data-memory word index |
| dbg_mem_val | output | 32 | Contents of the selected data word |
| wb_en | output | 1 | A register is written at the coming edge |
| wb_reg | output | 5 | Destination of that write |
| wb_data | output | 32 | Value of that write |

## Verification
The assertions check the following on every cycle:
- the PC steps by four unless a taken branch sits in the memory stage, and takes that branch's target when one does;
- a store in the memory stage never leads to a writeback event;
- a load's writeback carries the word the data array returned;
- register 0 reads as zero, and each register write lands;
- the writeback monitor stays quiet during reset.

Only the bench scenario can show the rest:
- the exact retirement cycle of each instruction;
- the values the four ALU operations produce;
- a same-cycle write followed by a read;
- sign extension of the offset;
- the three unsquashed slots after a taken branch, and the skipped instruction beyond them;
- the final memory image.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;

  localparam int XLEN = 32;
  localparam int RAW  = 5;

  localparam logic [5:0] OPC_RTYPE = 6'h00;
  localparam logic [5:0] OPC_LOAD  = 6'h23;
  localparam logic [5:0] OPC_STORE = 6'h2B;
  localparam logic [5:0] OPC_BEQ   = 6'h04;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;

  typedef enum logic [2:0] {K_BUBBLE, K_ALU, K_LOAD, K_STORE, K_BRANCH} kind_e;
  typedef enum logic [1:0] {A_ADD, A_SUB, A_AND, A_OR} aluop_e;

  typedef struct packed {
    logic [XLEN-1:0] pc4;
    logic [XLEN-1:0] instr;
  } ifid_t;

  typedef struct packed {
    kind_e           kind;
    aluop_e          alu;
    logic [XLEN-1:0] a;
    logic [XLEN-1:0] b;
    logic [XLEN-1:0] imm;
    logic [XLEN-1:0] pc4;
    logic [RAW-1:0]  dst;
  } idex_t;

  typedef struct packed {
    kind_e           kind;
    logic [XLEN-1:0] result;
    logic [XLEN-1:0] sdata;
    logic [XLEN-1:0] target;
    logic            taken;
    logic [RAW-1:0]  dst;
  } exmem_t;

  typedef struct packed {
    logic            wen;
    logic [RAW-1:0]  dst;
    logic [XLEN-1:0] value;
  } memwb_t;

endpackage

// File: rtl/pipe5_regfile.sv
module pipe5_regfile
  import pipe5_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [RAW-1:0]  waddr,
  input  logic [XLEN-1:0] wdata,
  input  logic [RAW-1:0]  ra_a,
  output logic [XLEN-1:0] rd_a,
  input  logic [RAW-1:0]  ra_b,
  output logic [XLEN-1:0] rd_b,
  input  logic [RAW-1:0]  ra_dbg,
  output logic [XLEN-1:0] rd_dbg
);

  localparam int NREG = 2 ** RAW;

  logic [XLEN-1:0] regs [NREG];
  logic            wr_live;

  assign wr_live = we && (waddr != '0);

  // Register 0 is never written, so it keeps the zero it gets at reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (wr_live) begin
      regs[waddr] <= wdata;
    end
  end

  // A write in the same cycle bypasses to the decode read (first half write).
  always_comb begin
    if (ra_a == '0)                    rd_a = '0;
    else if (wr_live && waddr == ra_a) rd_a = wdata;
    else                               rd_a = regs[ra_a];
    if (ra_b == '0)                    rd_b = '0;
    else if (wr_live && waddr == ra_b) rd_b = wdata;
    else                               rd_b = regs[ra_b];
  end

  assign rd_dbg = regs[ra_dbg];

  p_zero_reads_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_a == '0) |-> (rd_a == '0));

  p_write_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_live |=> (regs[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/pipe5_wordmem.sv
module pipe5_wordmem
  import pipe5_pkg::*;
#(
  parameter int AW  = 6,
  parameter int NRD = 1
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [AW-1:0]           waddr,
  input  logic [XLEN-1:0]         wdata,
  input  logic [NRD-1:0][AW-1:0]  raddr,
  output logic [NRD-1:0][XLEN-1:0] rdata
);

  localparam int WORDS = 2 ** AW;

  logic [XLEN-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata[p] = mem[raddr[p]];
  end

endmodule

// File: rtl/pipe5_execute.sv
module pipe5_execute
  import pipe5_pkg::*;
(
  input  idex_t  s,
  output exmem_t r
);

  always_comb begin
    r        = '0;
    r.kind   = s.kind;
    r.dst    = s.dst;
    r.sdata  = s.b;
    r.target = s.pc4 + {s.imm[XLEN-3:0], 2'b00};
    case (s.kind)
      K_ALU: begin
        case (s.alu)
          A_ADD:   r.result = s.a + s.b;
          A_SUB:   r.result = s.a - s.b;
          A_AND:   r.result = s.a & s.b;
          default: r.result = s.a | s.b;
        endcase
      end
      K_LOAD, K_STORE: r.result = s.a + s.imm;
      K_BRANCH:        r.taken  = (s.a == s.b);
      default:         r.result = '0;
    endcase
  end

endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
  import pipe5_pkg::*;
#(
  parameter int IMEM_AW = 6,
  parameter int DMEM_AW = 6,
  parameter int PAW     = (IMEM_AW > DMEM_AW) ? IMEM_AW : DMEM_AW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               prog_we,
  input  logic               prog_dmem,
  input  logic [PAW-1:0]     prog_addr,
  input  logic [XLEN-1:0]    prog_data,
  input  logic [RAW-1:0]     dbg_reg_sel,
  output logic [XLEN-1:0]    dbg_reg_val,
  input  logic [DMEM_AW-1:0] dbg_mem_sel,
  output logic [XLEN-1:0]    dbg_mem_val,
  output logic               wb_en,
  output logic [RAW-1:0]     wb_reg,
  output logic [XLEN-1:0]    wb_data
);

  logic [XLEN-1:0] pc_q, pc_d;
  ifid_t  ifid_q,  ifid_d;
  idex_t  idex_q,  idex_d;
  exmem_t exmem_q, exmem_d;
  memwb_t memwb_q, memwb_d;

  logic [0:0][XLEN-1:0]    imem_rd;
  logic [1:0][XLEN-1:0]    dmem_rd;
  logic [1:0][DMEM_AW-1:0] dmem_ra;
  logic [XLEN-1:0]         rf_a, rf_b;
  logic                    redirect;
  logic                    dmem_we;
  logic [DMEM_AW-1:0]      dmem_wa;
  logic [XLEN-1:0]         dmem_wd;

  // ---------------- fetch ----------------
  pipe5_wordmem #(.AW(IMEM_AW), .NRD(1)) u_imem (
    .clk   (clk),
    .we    (prog_we && !prog_dmem),
    .waddr (prog_addr[IMEM_AW-1:0]),
    .wdata (prog_data),
    .raddr (pc_q[IMEM_AW+1:2]),
    .rdata (imem_rd)
  );

  assign redirect = (exmem_q.kind == K_BRANCH) && exmem_q.taken;

  always_comb begin
    pc_d         = redirect ? exmem_q.target : pc_q + 32'd4;
    ifid_d.pc4   = pc_q + 32'd4;
    ifid_d.instr = imem_rd[0];
  end

  // ---------------- decode ----------------
  logic [5:0]     f_op, f_fn;
  logic [RAW-1:0] f_rs, f_rt, f_rd, f_sh;

  assign f_op = ifid_q.instr[31:26];
  assign f_rs = ifid_q.instr[25:21];
  assign f_rt = ifid_q.instr[20:16];
  assign f_rd = ifid_q.instr[15:11];
  assign f_sh = ifid_q.instr[10:6];
  assign f_fn = ifid_q.instr[5:0];

  pipe5_regfile u_rf (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (memwb_q.wen),
    .waddr  (memwb_q.dst),
    .wdata  (memwb_q.value),
    .ra_a   (f_rs),
    .rd_a   (rf_a),
    .ra_b   (f_rt),
    .rd_b   (rf_b),
    .ra_dbg (dbg_reg_sel),
    .rd_dbg (dbg_reg_val)
  );

  always_comb begin
    idex_d      = '0;
    idex_d.a    = rf_a;
    idex_d.b    = rf_b;
    idex_d.imm  = {{(XLEN-16){ifid_q.instr[15]}}, ifid_q.instr[15:0]};
    idex_d.pc4  = ifid_q.pc4;
    case (f_op)
      OPC_RTYPE: begin
        if (f_sh == '0) begin
          idex_d.dst  = f_rd;
          idex_d.kind = K_ALU;
          case (f_fn)
            FN_ADD:  idex_d.alu = A_ADD;
            FN_SUB:  idex_d.alu = A_SUB;
            FN_AND:  idex_d.alu = A_AND;
            FN_OR:   idex_d.alu = A_OR;
            default: begin idex_d.kind = K_BUBBLE; idex_d.dst = '0; end
          endcase
        end
      end
      OPC_LOAD:  begin idex_d.kind = K_LOAD; idex_d.dst = f_rt; end
      OPC_STORE: idex_d.kind = K_STORE;
      OPC_BEQ:   idex_d.kind = K_BRANCH;
      default:   idex_d.kind = K_BUBBLE;
    endcase
  end

  // ---------------- execute ----------------
  pipe5_execute u_ex (
    .s (idex_q),
    .r (exmem_d)
  );

  // ---------------- memory ----------------
  // Port 0 serves the pipeline, port 1 the debug read.
  assign dmem_ra[0] = exmem_q.result[DMEM_AW+1:2];
  assign dmem_ra[1] = dbg_mem_sel;
  assign dbg_mem_val = dmem_rd[1];

  always_comb begin
    if (prog_we && prog_dmem) begin
      dmem_we = 1'b1;
      dmem_wa = prog_addr[DMEM_AW-1:0];
      dmem_wd = prog_data;
    end else begin
      dmem_we = (exmem_q.kind == K_STORE);
      dmem_wa = exmem_q.result[DMEM_AW+1:2];
      dmem_wd = exmem_q.sdata;
    end
  end

  pipe5_wordmem #(.AW(DMEM_AW), .NRD(2)) u_dmem (
    .clk   (clk),
    .we    (dmem_we),
    .waddr (dmem_wa),
    .wdata (dmem_wd),
    .raddr (dmem_ra),
    .rdata (dmem_rd)
  );

  always_comb begin
    memwb_d.wen   = ((exmem_q.kind == K_ALU) || (exmem_q.kind == K_LOAD))
                    && (exmem_q.dst != '0);
    memwb_d.dst   = exmem_q.dst;
    memwb_d.value = (exmem_q.kind == K_LOAD) ? dmem_rd[0] : exmem_q.result;
  end

  // ---------------- writeback ----------------
  assign wb_en   = memwb_q.wen;
  assign wb_reg  = memwb_q.dst;
  assign wb_data = memwb_q.value;

  // ---------------- pipeline registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q    <= '0;
      ifid_q  <= '0;
      idex_q  <= '0;
      exmem_q <= '0;
      memwb_q <= '0;
    end else begin
      pc_q    <= pc_d;
      ifid_q  <= ifid_d;
      idex_q  <= idex_d;
      exmem_q <= exmem_d;
      memwb_q <= memwb_d;
    end
  end

  // ---------------- assertions ----------------
  p_pc_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !redirect |=> (pc_q == $past(pc_q) + 32'd4));

  p_pc_redirect_r5: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> (pc_q == $past(exmem_q.target)));

  p_store_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (exmem_q.kind == K_STORE) |=> !wb_en);

  p_load_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((exmem_q.kind == K_LOAD) && (exmem_q.dst != '0))
      |=> (wb_en && (wb_data == $past(dmem_rd[0]))));

  p_reset_bubble_r8: assert property (@(posedge clk)
    !rst_n |-> !wb_en);

endmodule

// File: tb/pipe5_core_tb.sv
module pipe5_core_tb;

  localparam int IAW   = 6;
  localparam int DAW   = 6;
  localparam int PAW   = 6;
  localparam int NSTEP = 30;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           prog_we;
  logic           prog_dmem;
  logic [PAW-1:0] prog_addr;
  logic [31:0]    prog_data;
  logic [4:0]     dbg_reg_sel;
  logic [31:0]    dbg_reg_val;
  logic [DAW-1:0] dbg_mem_sel;
  logic [31:0]    dbg_mem_val;
  logic           wb_en;
  logic [4:0]     wb_reg;
  logic [31:0]    wb_data;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  pipe5_core #(.IMEM_AW(IAW), .DMEM_AW(DAW), .PAW(PAW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .prog_we(prog_we), .prog_dmem(prog_dmem), .prog_addr(prog_addr), .prog_data(prog_data),
    .dbg_reg_sel(dbg_reg_sel), .dbg_reg_val(dbg_reg_val),
    .dbg_mem_sel(dbg_mem_sel), .dbg_mem_val(dbg_mem_val),
    .wb_en(wb_en), .wb_reg(wb_reg), .wb_data(wb_data)
  );

  // Expected writeback monitor after edge n (entry n-1): {en, reg, data}.
  localparam logic [37:0] EXP [NSTEP] = '{
    {1'b0, 5'd0, 32'd0},   {1'b0, 5'd0, 32'd0},  {1'b0, 5'd0, 32'd0},
    {1'b1, 5'd1, 32'd100}, {1'b1, 5'd2, 32'd30}, {1'b0, 5'd0, 32'd0},
    {1'b0, 5'd0, 32'd0},   {1'b1, 5'd3, 32'd70}, {1'b1, 5'd4, 32'd130},
    {1'b1, 5'd5, 32'd4},   {1'b1, 5'd6, 32'd126},{1'b0, 5'd0, 32'd0},
    {1'b0, 5'd0, 32'd0},   {1'b0, 5'd0, 32'd0},  {1'b0, 5'd0, 32'd0},
    {1'b0, 5'd0, 32'd0},   {1'b0, 5'd0, 32'd0},  {1'b1, 5'd8, 32'd122},
    {1'b0, 5'd0, 32'd0},   {1'b0, 5'd0, 32'd0},  {1'b1, 5'd9, 32'd70},
    {1'b1, 5'd10, 32'd70}, {1'b0, 5'd0, 32'd0},  {1'b0, 5'd0, 32'd0},
    {1'b0, 5'd0, 32'd0},   {1'b0, 5'd0, 32'd0},  {1'b0, 5'd0, 32'd0},
    {1'b0, 5'd0, 32'd0},   {1'b0, 5'd0, 32'd0},  {1'b0, 5'd0, 32'd0}
  };

  function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd,
                                         input logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt,
                                         input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic put(input logic sel, input int addr, input logic [31:0] data);
    @(negedge clk);
    prog_we   = 1'b1;
    prog_dmem = sel;
    prog_addr = PAW'(addr);
    prog_data = data;
  endtask

  task automatic peek_reg(input int idx, output logic [31:0] v);
    dbg_reg_sel = 5'(idx);
    #1 v = dbg_reg_val;
  endtask

  task automatic peek_mem(input int idx, output logic [31:0] v);
    dbg_mem_sel = DAW'(idx);
    #1 v = dbg_mem_val;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    logic [31:0] prog [64];
    logic [31:0] v;
    rst_n = 1'b0; prog_we = 1'b0; prog_dmem = 1'b0; prog_addr = '0; prog_data = '0;
    dbg_reg_sel = '0; dbg_mem_sel = '0;

    for (int i = 0; i < 64; i++) prog[i] = 32'h0;
    prog[0]  = enc_i(6'h23, 0, 1, 16'd4);        // load r1 <- [4]
    prog[1]  = enc_i(6'h23, 0, 2, 16'd8);        // load r2 <- [8]
    prog[4]  = enc_r(1, 2, 3, 6'h22);            // sub, r2 bypassed (R7)
    prog[5]  = enc_r(1, 2, 4, 6'h20);            // add
    prog[6]  = enc_r(1, 2, 5, 6'h24);            // and
    prog[7]  = enc_r(1, 2, 6, 6'h25);            // or
    prog[8]  = enc_i(6'h2B, 0, 3, 16'd12);       // store r3 -> [12]
    prog[9]  = enc_i(6'h04, 1, 1, 16'd4);        // taken branch to word 14
    prog[13] = enc_r(1, 1, 7, 6'h20);            // skipped
    prog[14] = enc_i(6'h04, 1, 2, 16'd1);        // not taken
    prog[15] = enc_r(6, 5, 8, 6'h22);            // r8 = 122
    prog[16] = enc_r(1, 1, 0, 6'h20);            // write to r0
    prog[17] = enc_i(6'h2B, 0, 4, 16'd16);       // store r4 -> [16]
    prog[18] = enc_i(6'h23, 0, 9, 16'd12);       // load r9 <- [12]
    prog[19] = enc_i(6'h23, 1, 10, 16'hFFA8);    // load r10 <- [100-88]

    for (int i = 0; i < 64; i++) put(1'b0, i, prog[i]);
    for (int i = 0; i < 64; i++) put(1'b1, i, (i == 1) ? 32'd100 : (i == 2) ? 32'd30 : 32'd0);
    @(negedge clk);
    prog_we = 1'b0;
    rst_n   = 1'b1;

    // R8: reset state before the first edge
    check("R8", "wb_en after reset", {31'd0, wb_en}, 32'd0);
    peek_reg(1, v);
    check("R8", "r1 after reset", v, 32'd0);

    // R1, R9: writeback timing walked from the table
    for (int n = 1; n <= NSTEP; n++) begin
      logic [37:0] e;
      @(posedge clk);
      @(negedge clk);
      e = EXP[n-1];
      check("R1 R9", $sformatf("wb_en edge %0d", n), {31'd0, wb_en}, {31'd0, e[37]});
      if (e[37]) begin
        check("R1", $sformatf("wb_reg edge %0d", n), {27'd0, wb_reg}, {27'd0, e[36:32]});
        check("R1", $sformatf("wb_data edge %0d", n), wb_data, e[31:0]);
      end
    end

    // Final architectural state
    peek_reg(0, v);  check("R6", "r0", v, 32'd0);
    peek_reg(1, v);  check("R3", "r1", v, 32'd100);
    peek_reg(2, v);  check("R3", "r2", v, 32'd30);
    peek_reg(3, v);  check("R7", "r3 sub", v, 32'd70);
    peek_reg(4, v);  check("R2", "r4 add", v, 32'd130);
    peek_reg(5, v);  check("R2", "r5 and", v, 32'd4);
    peek_reg(6, v);  check("R2", "r6 or", v, 32'd126);
    peek_reg(7, v);  check("R5", "r7 skipped", v, 32'd0);
    peek_reg(8, v);  check("R5", "r8 after untaken", v, 32'd122);
    peek_reg(9, v);  check("R3", "r9", v, 32'd70);
    peek_reg(10, v); check("R3", "r10 negative offset", v, 32'd70);
    peek_reg(11, v); check("R9", "r11 untouched", v, 32'd0);
    peek_mem(1, v);  check("R10", "dmem[1]", v, 32'd100);
    peek_mem(3, v);  check("R4", "dmem[3]", v, 32'd70);
    peek_mem(4, v);  check("R4", "dmem[4]", v, 32'd130);
    peek_mem(5, v);  check("R4", "dmem[5]", v, 32'd0);

    // R8: reset asserted mid-run clears state at once
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R8", "wb_en in reset", {31'd0, wb_en}, 32'd0);
    peek_reg(4, v);
    check("R8", "r4 in reset", v, 32'd0);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule